// File: doc/BRIEF.md
# Serial-Bus Clock and Frame Generator

This block derives the timing of a time-division serial bus from a 16.384 MHz master clock. An 11-bit frame counter, 2048 master cycles per 8 kHz frame, drives a 4.096 MHz clock, its inverse, a 2.048 MHz clock and its inverse, and an active-low frame pulse. Every output is decoded from that one counter, so after any correction all of them stay in phase with the frame pulse.

Phase correction is requested from outside on two request lines: one to speed the frame up and one to slow it down. A request takes effect only on a falling edge of the selected 8 kHz reference. That reference is either a pin or the 8 kHz signal from the T1 loop, and in the second case the block also drives that signal out on its 8 kHz pin. A reference held at a constant level gives free-running operation. Two minor-mode bits let the 4.096 MHz clock come from an external pin, and let the frame pulse pin act as an input that realigns the frame. Pad tri-stating is shown as output-enable signals.

Top module: `st_frame_timing`

## Requirements
- R1: While rst_n is low, with the internal clock source selected: fp_out_n=0, c4_out=0, c4n_out=1, c2_out=0, c2n_out=1.
- R2: With the internal source, take as cycle 0 the first master cycle in which fp_out_n is low. c4_out then reads 1,1,0,0 and repeats with a period of 4 cycles, so its falling edge lies two cycles inside the pulse. c4n_out is its inverse.
- R3: From the same cycle 0, c2_out reads 1,1,0,0,0,0,1,1 with a period of 8 cycles: it falls together with c4_out inside the pulse. c2n_out is its inverse.
- R4: fp_out_n is low for 4 consecutive master cycles. With no correction, successive falling edges are 2048 cycles apart.
- R5: c4n_oe equals c4n_en. c2_oe equals c2_en. c4_oe equals c4_int_sel (the 4.096 MHz pin drives only with the internal source). fp_oe is the inverse of fp_in_sel.
- R6: With single_clk=1, ref8k_oe=1, ref8k_out follows t1_8k_in, and t1_8k_in is the reference. With single_clk=0, ref8k_oe=0 and ref8k_in is the reference.
- R7: A falling edge of the reference with slow_req=1 and speed_req=0 lengthens that frame to 2049 cycles. With speed_req=1 and slow_req=0 the frame is shortened to 2047 cycles. With both requests high, no correction is made (2048).
- R8: A reference held constant high or low makes no correction, even with a request asserted, so frames stay at 2048 cycles.
- R9: With c4_int_sel=0, c4_oe=0. c4n_out is the inverse of c4_ext_in, two master cycles late. Each falling edge of c4_ext_in moves the counter on by one 4.096 MHz period, so c2_out toggles once per external clock period.
- R10: With fp_in_sel=1 and the internal source, a falling edge of fp_ext_in_n applied before edge k loads the counter to the last cycle of the frame at edge k+2. c4_out and c2_out read 1 after edge k+2 and read 0, with fp_out_n low, after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | active-low reset |
| single_clk | input | 1 | take the reference from the T1 loop and drive it out |
| ref8k_in | input | 1 | 8 kHz reference from the pin |
| t1_8k_in | input | 1 | 8 kHz signal from the T1 loop |
| ref8k_out | output | 1 | 8 kHz pin drive value |
| ref8k_oe | output | 1 | 8 kHz pin output enable |
| speed_req | input | 1 | request to shorten the frame |
| slow_req | input | 1 | request to lengthen the frame |
| c4_int_sel | input | 1 | 1: internal 4.096 MHz source; 0: external |
| fp_in_sel | input | 1 | 1: frame pulse pin is an input |
| c4_ext_in | input | 1 | external 4.096 MHz clock |
| fp_ext_in_n | input | 1 | external frame pulse, active low |
| c4n_en | input | 1 | enable for the inverse 4.096 MHz output |
| c2_en | input | 1 | enable for both 2.048 MHz outputs |
| c4_out | output | 1 | 4.096 MHz clock, falling edge in the pulse |
| c4_oe | output | 1 | 4.096 MHz pin output enable |
| c4n_out | output | 1 | inverse 4.096 MHz clock |
| c4n_oe | output | 1 | inverse 4.096 MHz output enable |
| c2_out | output | 1 | 2.048 MHz clock, falling edge in the pulse |
| c2n_out | output | 1 | inverse 2.048 MHz clock |
| c2_oe | output | 1 | 2.048 MHz outputs enable |
| fp_out_n | output | 1 | 8 kHz frame pulse, active low |
| fp_oe | output | 1 | frame pulse pin output enable |

## Verification
The clock and pulse outputs are decoded straight from the counter, so they change in the cycle after the edge that moves it. Enables and the reference pass-through are combinational and are checked right after the inputs are driven. Each asynchronous input passes through a two-stage synchroniser, so a reference, external-clock or frame-pulse edge driven before edge k acts on the counter at edge k+2. The bench samples on the falling clock edge and counts those three edges before looking. Correction effects are measured as the number of cycles between frame-pulse falling edges, which does not depend on where in the frame the reference edge falls.

// File: rtl/st_frame_timing.sv
module st_frame_timing #(
  parameter int CNT_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic single_clk,
  input  logic ref8k_in,
  input  logic t1_8k_in,
  output logic ref8k_out,
  output logic ref8k_oe,
  input  logic speed_req,
  input  logic slow_req,
  input  logic c4_int_sel,
  input  logic fp_in_sel,
  input  logic c4_ext_in,
  input  logic fp_ext_in_n,
  input  logic c4n_en,
  input  logic c2_en,
  output logic c4_out,
  output logic c4_oe,
  output logic c4n_out,
  output logic c4n_oe,
  output logic c2_out,
  output logic c2n_out,
  output logic c2_oe,
  output logic fp_out_n,
  output logic fp_oe
);
  localparam int FRAME_LEN = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_GRP = CNT_W'(FRAME_LEN - 4);

  logic [CNT_W-1:0] cnt;
  logic [2:0] ref_s, c4x_s, fpx_s;
  logic ref_fall, c4x_fall, fpx_fall;
  logic fp_load, ext_step, corr_slow, corr_fast;

  wire ref_sel = single_clk ? t1_8k_in : ref8k_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_s <= 3'b000;
      c4x_s <= 3'b000;
      fpx_s <= 3'b111;
    end else begin
      ref_s <= {ref_s[1:0], ref_sel};
      c4x_s <= {c4x_s[1:0], c4_ext_in};
      fpx_s <= {fpx_s[1:0], fp_ext_in_n};
    end

  assign ref_fall  = ref_s[2] & ~ref_s[1];
  assign c4x_fall  = c4x_s[2] & ~c4x_s[1];
  assign fpx_fall  = fpx_s[2] & ~fpx_s[1];
  assign fp_load   = fp_in_sel & fpx_fall;
  assign ext_step  = ~c4_int_sel & c4x_fall;
  assign corr_slow = c4_int_sel & ref_fall & slow_req & ~speed_req;
  assign corr_fast = c4_int_sel & ref_fall & speed_req & ~slow_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= '0;
    else if (fp_load)
      cnt <= c4_int_sel ? LAST : LAST_GRP;
    else if (!c4_int_sel) begin
      if (ext_step)
        cnt <= {cnt[CNT_W-1:2] + 1'b1, 2'b00};
    end else if (corr_fast)
      cnt <= cnt + CNT_W'(2);
    else if (!corr_slow)
      cnt <= cnt + CNT_W'(1);

  assign c4_out   = cnt[1];
  assign c4n_out  = ~(c4_int_sel ? cnt[1] : c4x_s[1]);
  assign c2_out   = cnt[2];
  assign c2n_out  = ~cnt[2];
  assign fp_out_n = ~((&cnt[CNT_W-1:1]) | ~(|cnt[CNT_W-1:1]));

  assign c4_oe     = c4_int_sel;
  assign c4n_oe    = c4n_en;
  assign c2_oe     = c2_en;
  assign fp_oe     = ~fp_in_sel;
  assign ref8k_oe  = single_clk;
  assign ref8k_out = t1_8k_in;

  // R8: with no reference edge the counter advances one step per cycle
  a_r8_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (c4_int_sel && !ref_fall && !fp_load) |=> cnt == $past(cnt) + CNT_W'(1));

  a_r7_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_slow && !fp_load) |=> cnt == $past(cnt));

  a_r7_fast_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_fast && !fp_load) |=> cnt == $past(cnt) + CNT_W'(2));

  a_r10_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_load && c4_int_sel) |=> (c4_out && c2_out && !fp_out_n));

  // R3: the 2.048 MHz clock changes only when the 4.096 MHz clock falls
  a_r3_c2_on_c4_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (c4_int_sel && $past(c4_int_sel) && !$past(fp_load) && $changed(c2_out))
      |-> $fell(c4_out));
endmodule

// File: tb/test_st_frame_timing.sv
module test_st_frame_timing;
  logic clk = 0, rst_n = 0;
  logic single_clk = 0, ref8k_in = 1, t1_8k_in = 1, speed_req = 0, slow_req = 0;
  logic c4_int_sel = 1, fp_in_sel = 0, c4_ext_in = 0, fp_ext_in_n = 1;
  logic c4n_en = 1, c2_en = 1;
  logic ref8k_out, ref8k_oe, c4_out, c4_oe, c4n_out, c4n_oe;
  logic c2_out, c2n_out, c2_oe, fp_out_n, fp_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  st_frame_timing i_st_frame_timing (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fp_fall(output int n);
    logic prev;
    n = 0;
    prev = fp_out_n;
    forever begin
      @(negedge clk);
      n++;
      if (prev && !fp_out_n) break;
      prev = fp_out_n;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(fp_out_n == 0, "R1 fp_out_n", fp_out_n, 0);
    chk(c4_out == 0 && c4n_out == 1, "R1 c4 pair", c4_out, 0);
    chk(c2_out == 0 && c2n_out == 1, "R1 c2 pair", c2_out, 0);
    rst_n = 1;
  endtask

  task automatic t_clocks;
    int n;
    int low = 0;
    wait_fp_fall(n);
    for (int i = 0; i < 16; i++) begin
      int e4 = (i % 4) < 2 ? 1 : 0;
      int e2 = ((i + 2) % 8) < 4 ? 1 : 0;
      chk(c4_out == e4 && c4n_out == !e4, "R2 c4 phase", c4_out, e4);
      chk(c2_out == e2 && c2n_out == !e2, "R3 c2 phase", c2_out, e2);
      if (!fp_out_n) low++;
      @(negedge clk);
    end
    chk(low == 4, "R4 pulse width", low, 4);
    wait_fp_fall(n);
    wait_fp_fall(n);
    chk(n == 2048, "R4 frame period", n, 2048);
  endtask

  task automatic t_enables;
    c4n_en = 0; c2_en = 1; #1;
    chk(c4n_oe == 0 && c2_oe == 1, "R5 c4n_oe", c4n_oe, 0);
    c4n_en = 1; c2_en = 0; #1;
    chk(c4n_oe == 1 && c2_oe == 0, "R5 c2_oe", c2_oe, 0);
    c2_en = 1; fp_in_sel = 1; #1;
    chk(fp_oe == 0 && c4_oe == 1, "R5 fp_oe", fp_oe, 0);
    fp_in_sel = 0; #1;
    chk(fp_oe == 1, "R5 fp_oe back", fp_oe, 1);
  endtask

  task automatic gap_with_ref_fall(input bit use_t1, output int n);
    int m;
    wait_fp_fall(n);
    repeat (100) @(negedge clk);
    if (use_t1) t1_8k_in = 0; else ref8k_in = 0;
    wait_fp_fall(m);
    n = m + 100;
    ref8k_in = 1; t1_8k_in = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_corrections;
    int n;
    slow_req = 1;
    gap_with_ref_fall(0, n);
    chk(n == 2049, "R7 slow frame", n, 2049);
    slow_req = 0; speed_req = 1;
    gap_with_ref_fall(0, n);
    chk(n == 2047, "R7 speed frame", n, 2047);
    slow_req = 1;
    gap_with_ref_fall(0, n);
    chk(n == 2048, "R7 both requests", n, 2048);
    speed_req = 0; slow_req = 0;
  endtask

  task automatic t_ref_source;
    int n;
    single_clk = 1; t1_8k_in = 0; #1;
    chk(ref8k_oe == 1 && ref8k_out == 0, "R6 drive low", ref8k_out, 0);
    t1_8k_in = 1; #1;
    chk(ref8k_out == 1, "R6 drive high", ref8k_out, 1);
    repeat (5) @(negedge clk);
    slow_req = 1;
    gap_with_ref_fall(1, n);
    chk(n == 2049, "R6 t1 reference", n, 2049);
    single_clk = 0; #1;
    chk(ref8k_oe == 0, "R6 oe off", ref8k_oe, 0);
    gap_with_ref_fall(1, n);
    chk(n == 2048, "R6 t1 ignored", n, 2048);
    slow_req = 0;
  endtask

  task automatic t_free_run;
    int n;
    slow_req = 1; ref8k_in = 1;
    wait_fp_fall(n); wait_fp_fall(n);
    chk(n == 2048, "R8 ref high", n, 2048);
    ref8k_in = 0; speed_req = 1; slow_req = 0;
    wait_fp_fall(n);
    speed_req = 0; slow_req = 1;
    wait_fp_fall(n); wait_fp_fall(n);
    chk(n == 2048, "R8 ref low", n, 2048);
    slow_req = 0; ref8k_in = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_ext_clock;
    logic hist [3];
    int tog = 0;
    logic prev_c2;
    c4_int_sel = 0; #1;
    chk(c4_oe == 0, "R9 c4_oe", c4_oe, 0);
    hist[0] = 0; hist[1] = 0; hist[2] = 0;
    for (int i = 0; i < 96; i++) begin
      @(negedge clk);
      if (i >= 2)
        chk(c4n_out == !hist[1], "R9 c4n follows ext", c4n_out, !hist[1]);
      if (i >= 32 && c2_out != prev_c2) tog++;
      prev_c2 = c2_out;
      hist[1] = hist[0];
      c4_ext_in = (i % 8) < 4;
      hist[0] = c4_ext_in;
    end
    chk(tog == 8, "R9 c2 toggles", tog, 8);
    c4_ext_in = 0;
    c4_int_sel = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_fp_input;
    int n;
    fp_in_sel = 1;
    wait_fp_fall(n);
    repeat (500) @(negedge clk);
    fp_ext_in_n = 0;
    repeat (3) @(negedge clk);
    chk(c4_out == 1 && c2_out == 1, "R10 load last cycle", c4_out, 1);
    @(negedge clk);
    chk(c4_out == 0 && c2_out == 0 && fp_out_n == 0, "R10 boundary", c4_out, 0);
    fp_ext_in_n = 1;
    wait_fp_fall(n);
    chk(n == 2046, "R10 next frame", n, 2046);
    fp_in_sel = 0;
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_clocks;
        t_enables;
        t_corrections;
        t_ref_source;
        t_free_run;
        t_ext_clock;
        t_fp_input;
        done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual 0 expected 1");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule